// File: doc/BRIEF.md
# Pattern Buffer Receiver and Tagger

This block takes in a fixed-length pattern buffer once per fiducial period. The buffer is 16 bytes (128 bits) and arrives as a byte stream; a start marker tags its first byte. The block assembles the bytes and checks the final byte against an 8-bit additive checksum. It also notes whether the previous frame was cut short. The finished frame waits inside the block until the next fiducial strobe.

On that strobe the block publishes an extended record. The record joins three parts: a 64-bit timestamp sampled at that edge, an 8-bit status word and the 128-bit buffer. Publishing sets a ready flag, and the downstream consumer clears that flag with an acknowledge pulse once it has read the record. A record that is published while the flag is still set replaces the unread one, and its status word marks the overrun.

Top module: `pbuf_tagger`

## Requirements
- R1: The first byte of a frame is the byte with `rx_valid` and `rx_start` both high. Byte k of the frame (k = 0..15) appears in `rec_out[8k+7:8k]` of the published record.
- R2: Status bit 0 (`rec_out[128]`) and `rec_err` are 1 exactly when the modulo-256 sum of bytes 0..14 differs from byte 15. Otherwise both are 0.
- R3: `rec_out[199:136]` holds the value of `ts_in` sampled on the clock edge where the record is published.
- R4: A start byte that arrives while 1 to 15 bytes of a frame are held discards the partial frame. The next published record then has status bit 2 (`rec_out[130]`) set, and any later record without a new discard has it clear. Valid bytes without a start while no frame is open are ignored.
- R5: Status bit 1 (`rec_out[129]`) is set when the record is published while `rec_ready` is still high and `rd_ack` is low. Otherwise it is 0.
- R6: A record is published only on a clock edge where `fid_strobe` is high and a complete frame is pending, and `rec_ready` is high one cycle later. A strobe with no pending frame changes no output.
- R7: `rd_ack` clears `rec_ready` on the next edge unless a record is published on that same edge.
- R8: `rec_out` stays unchanged between publications, and status bits 7..3 are always 0.
- R9: After reset, `rec_ready`, `rec_err` and `rec_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe on the receive stream |
| rx_start | input | 1 | Marks the first byte of a frame (qualified by rx_valid) |
| rx_data | input | 8 | Received byte |
| fid_strobe | input | 1 | One-cycle fiducial pulse that publishes a pending frame |
| ts_in | input | 64 | Free-running timestamp |
| rd_ack | input | 1 | Consumer acknowledge; clears the ready flag |
| rec_out | output | 200 | Extended record {timestamp, status, buffer} |
| rec_ready | output | 1 | A record is waiting to be read |
| rec_err | output | 1 | Checksum error of the current record |

## Verification
The assertions rely on `fid_strobe` and `rd_ack` being single-cycle pulses. They also rely on the last byte of a frame never landing on the same edge as a fiducial strobe, because the block would then publish the older pending frame. The stimulus drives every input on the falling clock edge. It sends each frame as back-to-back bytes and raises the strobe only after the frame's last byte has been taken. It mixes random byte contents, random checksum corruption and random skipped acknowledges with truncated frames and stray bytes that carry no start marker.

// File: rtl/pbuf_tagger.sv
module pbuf_tagger #(
  parameter int NBYTES = 16,
  parameter int TSW    = 64,
  parameter int STW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid,
  input  logic                      rx_start,
  input  logic [7:0]                rx_data,
  input  logic                      fid_strobe,
  input  logic [TSW-1:0]            ts_in,
  input  logic                      rd_ack,
  output logic [TSW+STW+NBYTES*8-1:0] rec_out,
  output logic                      rec_ready,
  output logic                      rec_err
);
  localparam int BW = NBYTES * 8;
  localparam int RW = TSW + STW + BW;
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] LASTI = CW'(NBYTES - 1);

  logic [CW-1:0] cnt;
  logic [BW-1:0] asm_buf, pend_buf;
  logic [7:0]    sum;
  logic          pend, pend_cerr, fr_seen;
  logic [RW-1:0] rec;

  logic [CW-1:0] idx;
  logic          take, abort, last, publish;
  logic [7:0]    sum_base;

  assign idx      = rx_start ? '0 : cnt;
  assign take     = rx_valid && (rx_start || cnt != '0);
  assign abort    = rx_valid && rx_start && cnt != '0;
  assign last     = take && idx == LASTI;
  assign publish  = fid_strobe && pend;
  assign sum_base = (idx == '0) ? 8'd0 : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      sum     <= '0;
      asm_buf <= '0;
    end else if (take) begin
      asm_buf[idx*8 +: 8] <= rx_data;
      if (!last) sum <= sum_base + rx_data;
      cnt <= last ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_cerr <= 1'b0;
      pend_buf  <= '0;
    end else begin
      if (publish) pend <= 1'b0;
      if (last) begin
        pend      <= 1'b1;
        pend_cerr <= (sum != rx_data);
        pend_buf  <= asm_buf;
        pend_buf[BW-8 +: 8] <= rx_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       fr_seen <= 1'b0;
    else if (abort)   fr_seen <= 1'b1;
    else if (publish) fr_seen <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec       <= '0;
      rec_ready <= 1'b0;
    end else if (publish) begin
      rec       <= {ts_in, {(STW-3){1'b0}}, fr_seen, rec_ready && !rd_ack, pend_cerr, pend_buf};
      rec_ready <= 1'b1;
    end else if (rd_ack) begin
      rec_ready <= 1'b0;
    end
  end

  assign rec_out = rec;
  assign rec_err = rec[BW];

  AST_RDY_ON_FID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_ready) |-> $past(fid_strobe)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !fid_strobe |=> !rec_ready); // R7
  AST_REC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fid_strobe |=> $stable(rec_out)); // R8
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    publish && rec_ready && !rd_ack |=> rec_out[BW+1]); // R5
  AST_STRAY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_start && cnt == '0 |=> cnt == '0); // R4
endmodule

// File: tb/sim_pbuf_tagger.sv
module sim_pbuf_tagger;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_start = 0, fid_strobe = 0, rd_ack = 0;
  logic [7:0] rx_data = 0;
  logic [63:0] ts_in = 0;
  logic [199:0] rec_out;
  logic rec_ready, rec_err;

  int errors = 0, checks = 0;
  logic [7:0] fb [16];
  bit m_ready = 0, m_partial = 0, m_fr = 0, m_cerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbuf_tagger u0 (.clk, .rst_n, .rx_valid, .rx_start, .rx_data, .fid_strobe,
                  .ts_in, .rd_ack, .rec_out, .rec_ready, .rec_err);

  task automatic chk(string req, logic [199:0] act, logic [199:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] csum();
    logic [7:0] s = 0;
    for (int i = 0; i < 15; i++) s += fb[i];
    return s;
  endfunction

  task automatic fill(bit bad);
    for (int i = 0; i < 15; i++) fb[i] = 8'($urandom);
    fb[15] = csum() ^ (bad ? 8'(1 + $urandom_range(0, 254)) : 8'd0);
  endtask

  task automatic send(int n);
    if (m_partial) m_fr = 1;
    m_partial = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_start = (i == 0); rx_data = fb[i];
    end
    @(negedge clk);
    rx_valid = 0; rx_start = 0;
    if (n < 16) m_partial = 1;
    else m_cerr = (csum() != fb[15]);
  endtask

  task automatic stray(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_start = 0; rx_data = 8'($urandom);
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic fiducial_pub();
    logic [63:0] ts = {$urandom, $urandom};
    logic [7:0] st;
    logic [127:0] b;
    st = {5'b0, m_fr, m_ready, m_cerr};
    for (int i = 0; i < 16; i++) b[i*8 +: 8] = fb[i];
    ts_in = ts; fid_strobe = 1;
    @(negedge clk);
    fid_strobe = 0;
    m_ready = 1; m_fr = 0;
    chk("R1 buffer", {72'b0, rec_out[127:0]}, {72'b0, b});
    chk("R2 cerr", {199'b0, rec_err}, {199'b0, m_cerr});
    chk("R3 ts", {136'b0, rec_out[199:136]}, {136'b0, ts});
    chk("R4 R5 R8 status", {192'b0, rec_out[135:128]}, {192'b0, st});
    chk("R6 ready", {199'b0, rec_ready}, 200'd1);
  endtask

  task automatic ack();
    rd_ack = 1;
    @(negedge clk);
    rd_ack = 0;
    m_ready = 0;
    chk("R7 ack clears", {199'b0, rec_ready}, 200'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [199:0] snap;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R9 reset rec", rec_out, 200'd0);
    chk("R9 reset flags", {198'b0, rec_ready, rec_err}, 200'd0);
    rst_n = 1;
    @(negedge clk);
    // R6: strobe with nothing pending
    fid_strobe = 1; ts_in = 64'hdead; @(negedge clk); fid_strobe = 0;
    chk("R6 no pending", {rec_ready, rec_out}, 201'd0);
    // good frame, then bad checksum with overrun
    fill(0); send(16); repeat (2) @(negedge clk); fiducial_pub();
    fill(1); send(16); @(negedge clk); fiducial_pub();
    ack();
    // R4 stray bytes and truncated frame
    stray(5); fill(0); send(7); fill(0); send(16); fiducial_pub();
    snap = rec_out;
    repeat (20) @(negedge clk);
    chk("R8 stable", rec_out, snap);
    ack();
    fill(0); send(16); fiducial_pub();
    ack();
    // random mix
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(0, 4) == 0) stray($urandom_range(1, 4));
      if ($urandom_range(0, 5) == 0) begin fill(0); send($urandom_range(1, 15)); end
      fill($urandom_range(0, 2) == 0);
      send(16);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      fiducial_pub();
      if ($urandom_range(0, 2) != 0) ack();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule